// File: doc/BRIEF.md
# Vertical Display Timing with Start-of-Frame Strobe

This block produces the vertical half of a display raster. On every horizontal line tick it moves a vertical line position forward and, when that position passes the programmed total, it returns to the top and advances a frame counter in the same tick. From the position it derives a vertical-blank flag and two single-tick strobes. The start-of-frame strobe fires a few lines ahead of the end of blanking. The advanced start-line strobe fires a programmable number of lines before the first visible line.

In interlaced mode the position steps by two lines per tick, and each field begins on its own parity. The even field begins at line 0 and the odd field at line 1. A field-parity flag toggles on every wrap. The strobe lead depends on three things: the scan mode, the field, and whether the scaler and the matching early-start option are both set. A composite status word puts the low frame-count bits above the line position. Both halves come from the same register edge, so a reader never sees a torn pair. Configuration arrives as plain input ports and must stay steady while the generator is enabled.

Top module: `vt_vertical_timing`

## Requirements
- R1: Only a line tick with the generator enabled changes the position. In progressive mode the position advances by 1 per tick and returns to 0 on the tick taken at line total minus 1.
- R2: The frame counter grows by exactly 1 on the tick that wraps the position and holds on every other cycle. It rolls from its all-ones value to 0.
- R3: In interlaced mode the position advances by 2 per tick. A wrap happens when the next value would reach total or beyond. The field flag toggles on each wrap; the even field (flag 0) restarts at line 0 and the odd field (flag 1) at line 1.
- R4: In progressive mode the start-of-frame strobe fires at line blank_end−2. It fires at blank_end−3 only when the scaler enable and the progressive early bit are both 1; every other combination keeps the lead at 2.
- R5: In interlaced mode the start-of-frame strobe fires at blank_end−4 in the even field and at blank_end−3 in the odd field. When the scaler enable and the interlaced early bit are both 1, these become blank_end−6 and blank_end−5.
- R6: The advanced start-line strobe fires at line blank_end−N in progressive mode, where N is the 4-bit advance input. In interlaced mode it fires at blank_end−2N in the even field and at blank_end−2N+1 in the odd field.
- R7: The vertical-blank flag is 1 when the position is at or above blank_start, or below blank_end, and 0 otherwise.
- R8: The status word equals {frame_count[STAT_FRAME_W-1:0], vpos}, with the frame bits in the upper field.
- R9: While the master enable is low, the position and the field flag are forced to 0 on the next clock, both strobes stay 0, and the frame counter keeps its value.
- R10: Each strobe is high only in a cycle where line_tick is 1, so one matching line gives a pulse one clock long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick | input | 1 | One-cycle pulse per horizontal line |
| cfg_master_en | input | 1 | Generator enable |
| cfg_interlace | input | 1 | 1 = interlaced, 0 = progressive |
| cfg_scaler_en | input | 1 | Scaler active (affects strobe lead) |
| cfg_prog_early | input | 1 | Early start option, progressive |
| cfg_intl_early | input | 1 | Early start option, interlaced |
| cfg_total | input | VPOS_W | Total lines per frame |
| cfg_blank_start | input | VPOS_W | First blanked line |
| cfg_blank_end | input | VPOS_W | First visible line |
| cfg_adv_lines | input | 4 | Advanced start-line lead in lines |
| vpos | output | VPOS_W | Current vertical position |
| field_odd | output | 1 | Current field parity |
| frame_count | output | FRAME_W | Frame counter |
| vblank | output | 1 | Vertical blank flag |
| sof_pulse | output | 1 | Start-of-frame strobe |
| adv_pulse | output | 1 | Advanced start-line strobe |
| status_word | output | STAT_FRAME_W+VPOS_W | Composite frame/position word |

## Verification
The bench builds the block with VPOS_W=8, FRAME_W=10 and STAT_FRAME_W=6. The narrow 10-bit frame counter can roll over from all-ones to zero within a couple of thousand line ticks. The 6-bit status slice also wraps many times during the run. A 20-line frame with blank end at 8 leaves room for every strobe lead, the deepest being the 6-line interlaced early lead. The resulting targets are even-field and odd-field lines that differ by one, so each parity is checked on its own.

// File: rtl/vt_pkg.sv
package vt_pkg;

  // Lines between start-of-frame strobe and the first visible line.
  function automatic logic [2:0] sof_lead(input logic intl, input logic odd,
                                          input logic scl, input logic p_early,
                                          input logic i_early);
    logic [2:0] lead;
    if (!intl)
      lead = (scl && p_early) ? 3'd3 : 3'd2;
    else if (scl && i_early)
      lead = odd ? 3'd5 : 3'd6;
    else
      lead = odd ? 3'd3 : 3'd4;
    return lead;
  endfunction

  // Advanced start-line lead: lines in progressive, doubled in interlaced.
  function automatic logic [4:0] adv_lead(input logic intl, input logic [3:0] n);
    return intl ? {n, 1'b0} : {1'b0, n};
  endfunction

endpackage

// File: rtl/vt_line_counter.sv
module vt_line_counter #(
  parameter int VPOS_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic              master_en,
  input  logic              interlace,
  input  logic [VPOS_W-1:0] total,
  output logic [VPOS_W-1:0] vpos,
  output logic              field_odd,
  output logic              wrap_evt
);
  localparam int CW = VPOS_W + 1;

  logic [1:0]    step;
  logic [CW-1:0] nxt;

  assign step     = interlace ? 2'd2 : 2'd1;
  assign nxt      = {1'b0, vpos} + CW'(step);
  assign wrap_evt = (nxt >= {1'b0, total});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpos      <= '0;
      field_odd <= 1'b0;
    end else if (!master_en) begin
      vpos      <= '0;
      field_odd <= 1'b0;
    end else if (line_tick) begin
      if (wrap_evt) begin
        field_odd <= interlace ? ~field_odd : 1'b0;
        vpos      <= (interlace && !field_odd) ? VPOS_W'(1) : '0;
      end else begin
        vpos <= nxt[VPOS_W-1:0];
        if (!interlace) field_odd <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vt_frame_counter.sv
module vt_frame_counter #(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  output logic [FRAME_W-1:0] frame_count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       frame_count <= '0;
    else if (advance) frame_count <= frame_count + 1'b1;
  end
endmodule

// File: rtl/vt_strobe_gen.sv
module vt_strobe_gen #(
  parameter int VPOS_W = 13
) (
  input  logic              line_tick,
  input  logic              master_en,
  input  logic              interlace,
  input  logic              scaler_en,
  input  logic              prog_early,
  input  logic              intl_early,
  input  logic [3:0]        adv_lines,
  input  logic [VPOS_W-1:0] blank_start,
  input  logic [VPOS_W-1:0] blank_end,
  input  logic [VPOS_W-1:0] vpos,
  input  logic              field_odd,
  output logic              vblank,
  output logic              sof_pulse,
  output logic              adv_pulse
);
  import vt_pkg::*;
  localparam int SW = VPOS_W + 2;

  logic          tick_ok;
  logic          odd_i;
  logic [SW-1:0] pos_x, end_x;
  logic          sof_hit, adv_hit;

  assign tick_ok = line_tick & master_en;
  assign odd_i   = interlace & field_odd;
  assign pos_x   = {2'b00, vpos};
  assign end_x   = {2'b00, blank_end};

  // Compare by adding the lead to the position, so no underflow is possible.
  assign sof_hit = (pos_x + SW'(sof_lead(interlace, odd_i, scaler_en,
                                          prog_early, intl_early))) == end_x;
  assign adv_hit = (pos_x + SW'(adv_lead(interlace, adv_lines))) ==
                   (end_x + SW'(odd_i));

  assign sof_pulse = tick_ok & sof_hit;
  assign adv_pulse = tick_ok & adv_hit;
  assign vblank    = (vpos >= blank_start) || (vpos < blank_end);
endmodule

// File: rtl/vt_vertical_timing.sv
module vt_vertical_timing #(
  parameter int VPOS_W       = 13,
  parameter int FRAME_W      = 24,
  parameter int STAT_FRAME_W = 16,
  localparam int STAT_W      = STAT_FRAME_W + VPOS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_tick,
  input  logic               cfg_master_en,
  input  logic               cfg_interlace,
  input  logic               cfg_scaler_en,
  input  logic               cfg_prog_early,
  input  logic               cfg_intl_early,
  input  logic [VPOS_W-1:0]  cfg_total,
  input  logic [VPOS_W-1:0]  cfg_blank_start,
  input  logic [VPOS_W-1:0]  cfg_blank_end,
  input  logic [3:0]         cfg_adv_lines,
  output logic [VPOS_W-1:0]  vpos,
  output logic               field_odd,
  output logic [FRAME_W-1:0] frame_count,
  output logic               vblank,
  output logic               sof_pulse,
  output logic               adv_pulse,
  output logic [STAT_W-1:0]  status_word
);
  logic wrap_evt;
  logic frame_adv;

  vt_line_counter #(.VPOS_W(VPOS_W)) u_line (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
    .master_en(cfg_master_en), .interlace(cfg_interlace), .total(cfg_total),
    .vpos(vpos), .field_odd(field_odd), .wrap_evt(wrap_evt)
  );

  assign frame_adv = line_tick & cfg_master_en & wrap_evt;

  vt_frame_counter #(.FRAME_W(FRAME_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .advance(frame_adv), .frame_count(frame_count)
  );

  vt_strobe_gen #(.VPOS_W(VPOS_W)) u_strobe (
    .line_tick(line_tick), .master_en(cfg_master_en),
    .interlace(cfg_interlace), .scaler_en(cfg_scaler_en),
    .prog_early(cfg_prog_early), .intl_early(cfg_intl_early),
    .adv_lines(cfg_adv_lines), .blank_start(cfg_blank_start),
    .blank_end(cfg_blank_end), .vpos(vpos), .field_odd(field_odd),
    .vblank(vblank), .sof_pulse(sof_pulse), .adv_pulse(adv_pulse)
  );

  // Both halves come from registers updated on the same edge.
  assign status_word = {frame_count[STAT_FRAME_W-1:0], vpos};
endmodule

// File: rtl/vt_vertical_timing_chk.sv
module vt_vertical_timing_chk #(
  parameter int VPOS_W  = 13,
  parameter int FRAME_W = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               line_tick,
  input logic               master_en,
  input logic               interlace,
  input logic [VPOS_W-1:0]  total,
  input logic [VPOS_W-1:0]  vpos,
  input logic               field_odd,
  input logic [FRAME_W-1:0] frame_count,
  input logic               sof_pulse,
  input logic               adv_pulse,
  input logic               wrap_evt
);
  a_r2_frame_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (line_tick && master_en && wrap_evt) |=>
      frame_count == FRAME_W'($past(frame_count) + 1'b1));

  a_r2_frame_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_tick && master_en && wrap_evt) |=> $stable(frame_count));

  a_r1_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && !line_tick) |=> $stable(vpos));

  a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    master_en |-> (vpos < total));

  a_r3_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (master_en && interlace) |-> (vpos[0] == field_odd));

  a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |=> (vpos == '0 && !field_odd));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !master_en |-> (!sof_pulse && !adv_pulse));

  a_r10_sof_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_pulse || adv_pulse) |-> line_tick);
endmodule

bind vt_vertical_timing vt_vertical_timing_chk #(
  .VPOS_W(VPOS_W), .FRAME_W(FRAME_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
  .master_en(cfg_master_en), .interlace(cfg_interlace), .total(cfg_total),
  .vpos(vpos), .field_odd(field_odd), .frame_count(frame_count),
  .sof_pulse(sof_pulse), .adv_pulse(adv_pulse), .wrap_evt(wrap_evt)
);

// File: tb/tb_vt_vertical_timing.sv
module tb_vt_vertical_timing;
  localparam int VW = 8;
  localparam int FW = 10;
  localparam int SF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_tick = 1'b0;
  logic men = 1'b0, intl = 1'b0, scl = 1'b0, pe = 1'b0, ie = 1'b1;
  logic [VW-1:0] total = 8'd20, bstart = 8'd16, bend = 8'd8;
  logic [3:0] advn = 4'd3;
  logic [VW-1:0] vpos;
  logic field_odd, vblank, sof_pulse, adv_pulse;
  logic [FW-1:0] frame_count;
  logic [SF+VW-1:0] status_word;

  always #5 clk = ~clk;

  vt_vertical_timing #(.VPOS_W(VW), .FRAME_W(FW), .STAT_FRAME_W(SF)) dut (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
    .cfg_master_en(men), .cfg_interlace(intl), .cfg_scaler_en(scl),
    .cfg_prog_early(pe), .cfg_intl_early(ie), .cfg_total(total),
    .cfg_blank_start(bstart), .cfg_blank_end(bend), .cfg_adv_lines(advn),
    .vpos(vpos), .field_odd(field_odd), .frame_count(frame_count),
    .vblank(vblank), .sof_pulse(sof_pulse), .adv_pulse(adv_pulse),
    .status_word(status_word)
  );

  int n_chk = 0, n_bad = 0;
  int mvpos = 0, mframe = 0;
  bit mfield = 0;
  logic s_sof, s_adv;
  logic [VW-1:0] s_vpos;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Reference model of one enabled tick, restated from R1..R3.
  task automatic model_tick();
    int st;
    st = intl ? 2 : 1;
    if (mvpos + st >= int'(total)) begin
      mfield = intl ? ~mfield : 1'b0;
      mvpos  = (intl && mfield) ? 1 : 0;
      mframe = (mframe + 1) % (1 << FW);
    end else begin
      mvpos = mvpos + st;
    end
  endtask

  // One line tick: strobes sampled mid-tick, state after the edge.
  task automatic tick();
    @(negedge clk);
    line_tick = 1'b1;
    #1;
    s_sof = sof_pulse; s_adv = adv_pulse; s_vpos = vpos;
    @(posedge clk);
    #1;
    line_tick = 1'b0;
    if (men) model_tick();
  endtask

  typedef struct packed {
    logic intl, scl, pe, ie;
    logic [7:0] sof_e, sof_o, adv_e, adv_o;
  } vec_t;

  // total 20, blank_start 16, blank_end 8, advance 3
  localparam vec_t VECS [8] = '{
    '{1'b0,1'b0,1'b0,1'b0, 8'd6, 8'd6, 8'd5, 8'd5},
    '{1'b0,1'b1,1'b0,1'b0, 8'd6, 8'd6, 8'd5, 8'd5},
    '{1'b0,1'b1,1'b1,1'b0, 8'd5, 8'd5, 8'd5, 8'd5},
    '{1'b0,1'b0,1'b1,1'b1, 8'd6, 8'd6, 8'd5, 8'd5},
    '{1'b0,1'b1,1'b0,1'b1, 8'd6, 8'd6, 8'd5, 8'd5},
    '{1'b1,1'b0,1'b0,1'b0, 8'd4, 8'd5, 8'd2, 8'd3},
    '{1'b1,1'b1,1'b0,1'b1, 8'd2, 8'd3, 8'd2, 8'd3},
    '{1'b1,1'b1,1'b1,1'b0, 8'd4, 8'd5, 8'd2, 8'd3}
  };

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // Reset state
    chk(vpos == 0, "R1 reset vpos", vpos, 0);
    chk(frame_count == 0, "R2 reset frame", frame_count, 0);
    chk(!sof_pulse && !adv_pulse, "R10 reset strobes", {sof_pulse, adv_pulse}, 0);
    chk(status_word == 0, "R8 reset status", status_word, 0);

    // Table walk
    foreach (VECS[i]) begin
      int nsof, nadv, exps, expa;
      @(negedge clk); men = 1'b0;
      @(negedge clk);
      intl = VECS[i].intl; scl = VECS[i].scl; pe = VECS[i].pe; ie = VECS[i].ie;
      men = 1'b1; mvpos = 0; mfield = 0;
      nsof = 0; nadv = 0;
      for (int t = 0; t < 40; t++) begin
        bit oddl;
        tick();
        oddl = intl && s_vpos[0];
        exps = oddl ? VECS[i].sof_o : VECS[i].sof_e;
        expa = oddl ? VECS[i].adv_o : VECS[i].adv_e;
        if (s_sof) begin
          nsof++;
          chk(s_vpos == exps, intl ? "R5 sof line" : "R4 sof line", s_vpos, exps);
        end
        if (s_adv) begin
          nadv++;
          chk(s_vpos == expa, "R6 adv line", s_vpos, expa);
        end
        chk(vpos == mvpos, intl ? "R3 vpos step" : "R1 vpos step", vpos, mvpos);
        chk(field_odd == mfield, "R3 field", field_odd, mfield);
        chk(frame_count == mframe, "R2 frame", frame_count, mframe);
        chk(vblank == (mvpos >= 16 || mvpos < 8), "R7 vblank", vblank,
            (mvpos >= 16 || mvpos < 8));
        chk(status_word == {mframe[SF-1:0], mvpos[VW-1:0]}, "R8 status",
            status_word, {mframe[SF-1:0], mvpos[VW-1:0]});
      end
      chk(nsof == (intl ? 4 : 2), intl ? "R5 sof count" : "R4 sof count", nsof, intl ? 4 : 2);
      chk(nadv == (intl ? 4 : 2), "R6 adv count", nadv, intl ? 4 : 2);
    end

    // Odd field begins at line 1 (R3)
    @(negedge clk); men = 1'b0;
    @(negedge clk); intl = 1'b1; scl = 1'b0; men = 1'b1; mvpos = 0; mfield = 0;
    repeat (10) tick();
    chk(vpos == 1 && field_odd, "R3 odd start", vpos, 1);

    // Master disable clears position, keeps frame, no strobes (R9)
    @(negedge clk); men = 1'b0;
    @(negedge clk);
    chk(vpos == 0 && !field_odd, "R9 clear", vpos, 0);
    for (int k = 0; k < 10; k++) begin
      tick();
      chk(!s_sof && !s_adv, "R9 no strobe", {s_sof, s_adv}, 0);
    end
    chk(vpos == 0, "R9 vpos hold", vpos, 0);
    chk(frame_count == mframe, "R9 frame hold", frame_count, mframe);

    // Parked on the strobe line without a tick (R10, R1)
    @(negedge clk); intl = 1'b0; men = 1'b1; mvpos = 0; mfield = 0;
    repeat (6) tick();
    repeat (3) @(negedge clk);
    chk(vpos == 6, "R1 hold without tick", vpos, 6);
    chk(!sof_pulse, "R10 no tick no strobe", sof_pulse, 0);
    tick();
    chk(s_sof, "R10 strobe on tick", s_sof, 1);

    // Frame rollover with a 2-line frame (R2)
    @(negedge clk); men = 1'b0;
    @(negedge clk); total = 8'd2; bstart = 8'd1; bend = 8'd1;
    men = 1'b1; mvpos = 0; mfield = 0;
    while (!(mframe == (1 << FW) - 1 && mvpos == 1)) tick();
    chk(frame_count == (1 << FW) - 1, "R2 at max", frame_count, (1 << FW) - 1);
    tick();
    chk(frame_count == 0 && vpos == 0, "R2 rollover", frame_count, 0);
    tick();
    chk(frame_count == 0 && vpos == 1, "R2 mid-frame hold", frame_count, 0);

    finish_run();
  end
endmodule